// File: doc/BRIEF.md
# Output Clock Gate with Powerdown and Relock Wait

This block sits between a generated clock and the output pad driver. It decides when the clock reaches the pin. One control pin switches the output on and off. A configuration bit selects what that pin means. In powerdown mode a low level powers the core down. In output-enable mode a low level only disables the output. In both modes a high level means "run". In powerdown the block also drops a core-run signal, which stops the oscillator and PLL. When the core comes back, the block holds the output off until the PLL has relocked. The relock is modelled by a cycle counter or by an external lock indication, whichever arrives first.

A second configuration bit selects how the output is disabled. In synchronous mode the block waits for a falling edge of the clock, so no high pulse is ever shortened. In asynchronous mode the output is cut at once from the raw pin, whatever the clock phase. Turning the output back on is always aligned to a falling edge of the clock. The tri-state enable for the pad is arranged so that the pad is never released while the gated clock is high.

Top module: `clk_out_gate`

## Requirements
- R1: The control pin is active high in both modes. With `cfg_pwrdn_mode`=1 (powerdown mode), a low pin powers the core down. With `cfg_pwrdn_mode`=0 (output-enable mode), a low pin disables the output. A high pin lets the clock run once any relock wait has ended.
- R2: Whenever the output is disabled, `clk_out` stays low and `pad_oe` is 0.
- R3: In powerdown mode a low pin drives `core_run` to 0. In output-enable mode `core_run` never falls, whatever the pin does.
- R4: With `cfg_async`=1, a low pin forces `clk_out` and `pad_oe` low at once, even in the middle of a clock high phase.
- R5: With `cfg_async`=0, disabling never cuts a high phase of `clk_out`. `clk_out` falls only together with a falling edge of `clk`.
- R6: Re-enabling works the same in both settings. The gate opens on a falling edge of `clk`, so `clk_out` stays low for the rest of any high phase in progress. `clk_out` then runs full pulses within four clock cycles of the pin rising, unless a relock wait is pending.
- R7: On leaving powerdown, and on leaving reset, `lock_wait` is 1 for exactly LOCK_CYCLES cycles when `lock_in` stays 0. While `lock_wait` is 1 the output stays disabled.
- R8: A high `lock_in` during a relock wait ends the wait on the next rising edge of `clk`.
- R9: `clk_out` never goes high while `pad_oe` is 0. In synchronous mode `pad_oe` falls only while `clk_out` is low.
- R10: While `rst` is 1: `clk_out`=0, `pad_oe`=0, `core_run`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generated clock to be gated; also the block's own clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pwrdn_mode | input | 1 | 1: pin acts as active-low powerdown; 0: pin acts as active-high output enable |
| cfg_async | input | 1 | 1: disable immediately; 0: disable on a falling clock edge |
| ctl_pin | input | 1 | Asynchronous control pin, high means run |
| lock_in | input | 1 | External PLL lock indication, ends a relock wait early |
| clk_out | output | 1 | Gated clock to the pad driver |
| pad_oe | output | 1 | Pad driver enable; 0 leaves the pad to its weak pull-down |
| core_run | output | 1 | 1 keeps the oscillator and PLL running; 0 stops them |
| lock_wait | output | 1 | 1 while the output is held off waiting for relock |

## Verification
The hardest situation to reach is a control-pin change that falls inside a high phase of `clk`, in each disable setting. There the synchronous and asynchronous paths give different results, and the re-enable alignment can be seen. The bench times the pin edges one nanosecond after a rising clock edge. It then samples `clk_out` a fraction of a nanosecond later. This shows whether the high phase was cut or kept, and whether the gate reopened mid-phase. The relock window is measured by counting the falling edges during which `lock_wait` is high. `pad_oe` is checked over that same span.

// File: rtl/clk_out_gate_pkg.sv
package clk_out_gate_pkg;
  typedef enum logic {
    PIN_IS_OE    = 1'b0,
    PIN_IS_PWRDN = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cg_relock.sv
module cg_relock #(
  parameter int LOCK_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic lock_in,
  output logic core_run,
  output logic lock_wait
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run  <= 1'b0;
      lock_wait <= 1'b0;
      cnt       <= '0;
    end else if (pd_req) begin
      core_run  <= 1'b0;
      lock_wait <= 1'b0;
      cnt       <= '0;
    end else if (!core_run) begin
      core_run  <= 1'b1;
      lock_wait <= 1'b1;
      cnt       <= '0;
    end else if (lock_wait) begin
      if (lock_in || cnt == LAST) begin
        lock_wait <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/cg_gate.sv
module cg_gate (
  input  logic clk,
  input  logic rst,
  input  logic run_ok,
  input  logic kill,
  output logic gate_en,
  output logic clk_out,
  output logic pad_oe
);
  always_ff @(negedge clk) begin
    if (rst) gate_en <= 1'b0;
    else     gate_en <= run_ok;
  end

  assign clk_out = clk & gate_en & ~kill;
  assign pad_oe  = (run_ok | gate_en) & ~kill & ~rst;
endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
  import clk_out_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 600000
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_pwrdn_mode,
  input  logic cfg_async,
  input  logic ctl_pin,
  input  logic lock_in,
  output logic clk_out,
  output logic pad_oe,
  output logic core_run,
  output logic lock_wait
);
  logic pin_s;
  logic pd_req;
  logic run_ok;
  logic kill;
  logic gate_en;

  cg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_pin),
    .q   (pin_s)
  );

  assign pd_req = (pin_mode_e'(cfg_pwrdn_mode) == PIN_IS_PWRDN) && !pin_s;

  cg_relock #(.LOCK_CYCLES(LOCK_CYCLES)) u_relock (
    .clk       (clk),
    .rst       (rst),
    .pd_req    (pd_req),
    .lock_in   (lock_in),
    .core_run  (core_run),
    .lock_wait (lock_wait)
  );

  assign run_ok = pin_s & core_run & ~lock_wait;
  assign kill   = cfg_async & ~ctl_pin;

  cg_gate u_gate (
    .clk     (clk),
    .rst     (rst),
    .run_ok  (run_ok),
    .kill    (kill),
    .gate_en (gate_en),
    .clk_out (clk_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/clk_out_gate_chk.sv
module clk_out_gate_chk #(
  parameter int LOCK_CYCLES = 600000
) (
  input logic clk,
  input logic rst,
  input logic cfg_pwrdn_mode,
  input logic cfg_async,
  input logic clk_out,
  input logic pad_oe,
  input logic core_run,
  input logic lock_wait,
  input logic gate_en
);
  int unsigned lw_len;

  always_ff @(posedge clk) begin
    if (rst || !lock_wait) lw_len <= 0;
    else                   lw_len <= lw_len + 1;
  end

  p_wait_bounded_r7: assert property (@(posedge clk) disable iff (rst)
    lw_len <= LOCK_CYCLES);

  p_relock_on_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(core_run) |-> lock_wait);

  p_gate_shut_in_wait_r7: assert property (@(posedge clk) disable iff (rst)
    lock_wait |-> !gate_en);

  p_gate_shut_when_down_r3: assert property (@(posedge clk) disable iff (rst)
    !core_run |-> !gate_en);

  p_core_kept_in_oe_r3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_pwrdn_mode && $past(!cfg_pwrdn_mode)) |-> !$fell(core_run));

  always @(posedge clk_out) begin
    if (!rst) begin
      p_pad_driven_r9: assert (pad_oe);
    end
  end

  always @(negedge clk_out) begin
    if (!rst && !cfg_async) begin
      p_full_high_r5: assert (!clk);
    end
  end
endmodule

bind clk_out_gate clk_out_gate_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_pwrdn_mode (cfg_pwrdn_mode),
  .cfg_async      (cfg_async),
  .clk_out        (clk_out),
  .pad_oe         (pad_oe),
  .core_run       (core_run),
  .lock_wait      (lock_wait),
  .gate_en        (gate_en)
);

// File: tb/clk_out_gate_bench.sv
`timescale 1ns/1ps
module clk_out_gate_bench;
  localparam int LOCK = 16;

  logic clk = 1'b0;
  logic rst, cfg_pwrdn_mode, cfg_async, ctl_pin, lock_in;
  logic clk_out, pad_oe, core_run, lock_wait;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  clk_out_gate #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) u_clk_out_gate (
    .clk(clk), .rst(rst), .cfg_pwrdn_mode(cfg_pwrdn_mode), .cfg_async(cfg_async),
    .ctl_pin(ctl_pin), .lock_in(lock_in), .clk_out(clk_out), .pad_oe(pad_oe),
    .core_run(core_run), .lock_wait(lock_wait)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_lock(output int n, output int leaks);
    n = 0;
    leaks = 0;
    for (int i = 0; i < 50 && !lock_wait; i++) begin
      @(negedge clk); #1;
    end
    while (lock_wait && n < 1000) begin
      n++;
      if (pad_oe || clk_out) leaks++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    chk(pad_oe == 1'b0, "R10 pad_oe", pad_oe, 0);
    chk(clk_out == 1'b0, "R10 clk_out", clk_out, 0);
    chk(core_run == 1'b0, "R10 core_run", core_run, 0);
  endtask

  task automatic t_powerup();
    int n, leaks;
    rst = 1'b0;
    count_lock(n, leaks);
    chk(n == LOCK, "R7 wait length after reset", n, LOCK);
    chk(leaks == 0, "R7 output held in wait", leaks, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R1 running high phase", clk_out, 1);
    chk(pad_oe == 1'b1, "R1 pad driven", pad_oe, 1);
    @(negedge clk); #1;
    chk(clk_out == 1'b0, "R1 running low phase", clk_out, 0);
  endtask

  task automatic t_sync_oe();
    cfg_pwrdn_mode = 1'b0;
    cfg_async = 1'b0;
    @(posedge clk); #0.5;
    ctl_pin = 1'b0;
    #0.5;
    chk(clk_out == 1'b1, "R5 high phase kept", clk_out, 1);
    repeat (4) @(posedge clk);
    #1;
    chk(clk_out == 1'b0, "R2 clk_out off", clk_out, 0);
    chk(pad_oe == 1'b0, "R2 pad released", pad_oe, 0);
    chk(core_run == 1'b1, "R3 core kept in oe mode", core_run, 1);
    ctl_pin = 1'b1;
    #0.2;
    chk(clk_out == 1'b0, "R6 no mid-phase start", clk_out, 0);
    repeat (4) @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R6 fast re-enable", clk_out, 1);
    chk(lock_wait == 1'b0, "R6 no relock in oe mode", lock_wait, 0);
  endtask

  task automatic t_async();
    cfg_async = 1'b1;
    @(posedge clk); #1;
    ctl_pin = 1'b0;
    #0.2;
    chk(clk_out == 1'b0, "R4 immediate cut", clk_out, 0);
    chk(pad_oe == 1'b0, "R4 pad released at once", pad_oe, 0);
    repeat (5) @(posedge clk);
    #1;
    ctl_pin = 1'b1;
    #0.2;
    chk(clk_out == 1'b0, "R6 async mode start aligned", clk_out, 0);
    repeat (4) @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R6 async re-enable runs", clk_out, 1);
    chk(pad_oe == 1'b1, "R6 pad driven again", pad_oe, 1);
    cfg_async = 1'b0;
  endtask

  task automatic t_powerdown();
    int n, leaks;
    cfg_pwrdn_mode = 1'b1;
    @(posedge clk); #1;
    ctl_pin = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(core_run == 1'b0, "R3 core stopped", core_run, 0);
    chk(pad_oe == 1'b0, "R2 pad released in powerdown", pad_oe, 0);
    chk(clk_out == 1'b0, "R2 clock off in powerdown", clk_out, 0);
    ctl_pin = 1'b1;
    count_lock(n, leaks);
    chk(n == LOCK, "R7 relock length", n, LOCK);
    chk(leaks == 0, "R7 output held during relock", leaks, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R1 running after relock", clk_out, 1);
  endtask

  task automatic t_lock_early();
    @(posedge clk); #1;
    ctl_pin = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    ctl_pin = 1'b1;
    for (int i = 0; i < 20 && !lock_wait; i++) begin
      @(negedge clk); #1;
    end
    chk(lock_wait == 1'b1, "R8 wait entered", lock_wait, 1);
    lock_in = 1'b1;
    @(posedge clk); #1;
    chk(lock_wait == 1'b0, "R8 early end", lock_wait, 0);
    lock_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(clk_out == 1'b1, "R8 running after early lock", clk_out, 1);
  endtask

  initial begin
    rst = 1'b1;
    cfg_pwrdn_mode = 1'b0;
    cfg_async = 1'b0;
    ctl_pin = 1'b1;
    lock_in = 1'b0;
    repeat (4) @(posedge clk);
    t_reset();
    t_powerup();
    t_sync_oe();
    t_async();
    t_powerdown();
    t_lock_early();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule